// File: doc/BRIEF.md
# Paced SAR Converter Serial Reader

This block sits on the host side of an external 16-bit successive-approximation converter that has no busy or interrupt output. The converter starts a conversion when its chip select is pulled low, and the host must supply the serial clock. The block therefore does three jobs. It starts a frame at a programmable rate. It generates every serial clock edge of the frame. It assembles the returned bits into a sample word.

Each frame is a fixed count of serial clocks. Six leading clocks give the converter time to convert, and their data is thrown away. Sixteen more clocks then return the result, MSB first. The controller samples the data line on each rising serial clock edge. The only thing that sets the sample rate is how often chip select falls. Two rates are available, chosen by a select input. The default values of the period parameters give 1 kHz and 256 Hz from a 125 MHz system clock. At the end of the frame chip select rises, and a one-cycle strobe presents the finished word to the rest of the chip.

Top module: `sar_pacer`

## Requirements
- R1: While reset is held and on the cycles after its release, `cs_n` is 1, `ser_clk` is 1, `sample_valid` is 0 and `sample_data` is 0.
- R2: The interval between consecutive falling edges of `cs_n` is FAST_PERIOD system clocks when `rate_sel` was 1 at the earlier falling edge, and SLOW_PERIOD system clocks when it was 0.
- R3: `ser_clk` stays 1 whenever `cs_n` is 1. Each frame contains exactly LEAD_CLKS+DATA_W (22) rising edges of `ser_clk`. The `ser_clk` period inside a frame is 2*HALF_DIV system clocks.
- R4: `sample_data` holds the data-line values sampled at rising serial edges number LEAD_CLKS+1 to LEAD_CLKS+DATA_W, with the first of these values in bit DATA_W-1 (MSB first). Values on the data line during the first LEAD_CLKS edges have no effect on the word.
- R5: `sample_valid` is 1 for exactly one cycle per completed frame, in the same cycle that `cs_n` rises. `sample_data` keeps that word until the next strobe.
- R6: Between two frames, `cs_n` stays 1 for at least 2*HALF_DIV system clocks (one serial clock period).
- R7: A change of `rate_sel` between two falling edges of `cs_n` does not change the interval already in progress. It applies from the next falling edge.
- R8: A reset applied in the middle of a frame discards that frame. No `sample_valid` occurs until the first complete frame after reset, and that frame delivers the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | Rate select: 1 = fast period, 0 = slow period |
| ser_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select; its falling edge starts a conversion |
| ser_clk | output | 1 | Serial clock to the converter; idles high |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| sample_data | output | DATA_W | Last completed sample word |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of a frame. At that moment a partly shifted word and a running bit count must both vanish without producing a strobe. The bench waits for a chip select falling edge, lets about half the serial clocks pass, and then pulses reset. It then checks that no strobe appears before the next complete frame and that this frame returns the whole word. A second hard case is a rate change in mid-period. The bench flips the select between two chip select falls and measures the two intervals that follow.

// File: rtl/sar_pacer_pkg.sv
package sar_pacer_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_TAIL = 2'd2
    } seq_state_t;

    // Smallest period that still leaves one serial clock period of idle time
    // between frames: frame (2*total+1)*half, then an idle gap of 2*half.
    function automatic int unsigned min_period(int unsigned total, int unsigned half);
        return (2 * total + 3) * half + 2;
    endfunction

endpackage

// File: rtl/sar_rate_timer.sv
module sar_rate_timer #(
    parameter int unsigned FAST_PERIOD = 125000,
    parameter int unsigned SLOW_PERIOD = 488281,
    parameter int unsigned CNT_W       = 19
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel,
    output logic start
);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_PERIOD - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign start = (cnt == last);

    // The period for the next interval is chosen at the edge that starts a frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            last <= SLOW_LAST;
        end else if (start) begin
            cnt  <= '0;
            last <= rate_sel ? FAST_LAST : SLOW_LAST;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
    parameter int unsigned HALF_DIV = 25,
    parameter int unsigned HW       = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ser_clk,
    output logic tick_rise,
    output logic tick_fall
);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);

    logic [HW-1:0] half;
    logic          term;

    assign term      = run && (half == HALF_LAST);
    assign tick_rise = term && !ser_clk;
    assign tick_fall = term && ser_clk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half    <= '0;
            ser_clk <= 1'b1;
        end else if (term) begin
            half    <= '0;
            ser_clk <= ~ser_clk;
        end else begin
            half    <= half + 1'b1;
        end
    end
endmodule

// File: rtl/sar_capture.sv
module sar_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[DATA_W-2:0], ser_in};
        end
    end
endmodule

// File: rtl/sar_pacer.sv
module sar_pacer
    import sar_pacer_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned LEAD_CLKS   = 6,
    parameter int unsigned HALF_DIV    = 25,
    parameter int unsigned FAST_PERIOD = 125000,
    parameter int unsigned SLOW_PERIOD = 488281
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_sel,
    input  logic              ser_in,
    output logic              cs_n,
    output logic              ser_clk,
    output logic              sample_valid,
    output logic [DATA_W-1:0] sample_data
);
    localparam int unsigned TOTAL  = LEAD_CLKS + DATA_W;
    localparam int unsigned EW     = $clog2(TOTAL + 1);
    localparam int unsigned HW     = $clog2(HALF_DIV + 1);
    localparam int unsigned MAXP   = (FAST_PERIOD > SLOW_PERIOD) ? FAST_PERIOD : SLOW_PERIOD;
    localparam int unsigned CNT_W  = $clog2(MAXP + 1);
    localparam int unsigned MINP   = min_period(TOTAL, HALF_DIV);
    localparam logic [EW-1:0] EDGE_LAST = EW'(TOTAL - 1);
    localparam logic [EW-1:0] LEAD_E    = EW'(LEAD_CLKS);
    localparam logic [HW-1:0] TAIL_LAST = HW'(HALF_DIV - 1);

    seq_state_t        state;
    logic              run;
    logic [EW-1:0]     edge_cnt;
    logic [HW-1:0]     tail_cnt;
    logic              start;
    logic              tick_rise;
    logic              tick_fall;
    logic              shift_en;
    logic              clear;
    logic [DATA_W-1:0] word;

    if (FAST_PERIOD < MINP || SLOW_PERIOD < MINP || HALF_DIV < 2) begin : g_bad_params
        initial $display("sar_pacer: period parameters too short for one frame plus gap");
    end

    sar_rate_timer #(
        .FAST_PERIOD(FAST_PERIOD),
        .SLOW_PERIOD(SLOW_PERIOD),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .rate_sel(rate_sel),
        .start   (start)
    );

    sar_sclk_gen #(
        .HALF_DIV(HALF_DIV),
        .HW      (HW)
    ) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .ser_clk  (ser_clk),
        .tick_rise(tick_rise),
        .tick_fall(tick_fall)
    );

    assign clear    = (state == SEQ_IDLE) && start;
    assign shift_en = (state == SEQ_RUN) && tick_rise && (edge_cnt >= LEAD_E);

    sar_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .shift_en(shift_en),
        .ser_in  (ser_in),
        .word    (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SEQ_IDLE;
            cs_n         <= 1'b1;
            run          <= 1'b0;
            edge_cnt     <= '0;
            tail_cnt     <= '0;
            sample_valid <= 1'b0;
            sample_data  <= '0;
        end else begin
            sample_valid <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        cs_n     <= 1'b0;
                        run      <= 1'b1;
                        edge_cnt <= '0;
                        state    <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (tick_rise) begin
                        edge_cnt <= edge_cnt + 1'b1;
                        if (edge_cnt == EDGE_LAST) begin
                            run      <= 1'b0;
                            tail_cnt <= '0;
                            state    <= SEQ_TAIL;
                        end
                    end
                end
                SEQ_TAIL: begin
                    tail_cnt <= tail_cnt + 1'b1;
                    if (tail_cnt == TAIL_LAST) begin
                        cs_n         <= 1'b1;
                        sample_valid <= 1'b1;
                        sample_data  <= word;
                        state        <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    logic unused_fall;
    assign unused_fall = tick_fall;
endmodule

// File: rtl/sar_pacer_chk.sv
module sar_pacer_chk #(
    parameter int unsigned TOTAL    = 22,
    parameter int unsigned HALF_DIV = 25
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic ser_clk,
    input logic sample_valid
);
    logic        cs_q;
    logic        sclk_q;
    logic [7:0]  rise_cnt;
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q     <= 1'b1;
            sclk_q   <= 1'b1;
            rise_cnt <= '0;
            hi_cnt   <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= ser_clk;
            if (!cs_n && cs_q)
                rise_cnt <= '0;
            else if (!cs_n && ser_clk && !sclk_q)
                rise_cnt <= rise_cnt + 1'b1;
            if (!cs_n)
                hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R5: strobe only with the rising chip select
    a_r5_valid_on_rise: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $rose(cs_n));
    // R5: every rising chip select carries a strobe
    a_r5_rise_has_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> sample_valid);
    // R5: strobe lasts one cycle
    a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);
    // R3: serial clock parked high outside a frame
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> ser_clk);
    // R3: fixed count of serial clock rising edges per frame
    a_r3_edge_count: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (rise_cnt == 8'(TOTAL)));
    // R6: idle gap of at least one serial period before each frame
    a_r6_idle_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_cnt >= 16'(2 * HALF_DIV)));
endmodule

bind sar_pacer sar_pacer_chk #(
    .TOTAL   (LEAD_CLKS + DATA_W),
    .HALF_DIV(HALF_DIV)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .ser_clk     (ser_clk),
    .sample_valid(sample_valid)
);

// File: tb/tb_sar_pacer.sv
`timescale 1ns/1ps
module tb_sar_pacer;
    localparam int DATA_W = 16;
    localparam int LEAD   = 6;
    localparam int TOTAL  = LEAD + DATA_W;
    localparam int HALF   = 2;
    localparam int FASTP  = 120;
    localparam int SLOWP  = 200;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rate_sel = 1'b0;
    logic              ser_in = 1'b0;
    logic              cs_n;
    logic              ser_clk;
    logic              sample_valid;
    logic [DATA_W-1:0] sample_data;

    always #4 clk = ~clk;

    sar_pacer #(
        .DATA_W(DATA_W), .LEAD_CLKS(LEAD), .HALF_DIV(HALF),
        .FAST_PERIOD(FASTP), .SLOW_PERIOD(SLOWP)
    ) dut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .ser_in(ser_in),
        .cs_n(cs_n), .ser_clk(ser_clk),
        .sample_valid(sample_valid), .sample_data(sample_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // converter model: drives a bit after each falling serial edge
    logic [DATA_W-1:0] conv_word = '0;
    logic              lead_val  = 1'b1;
    int                fcnt = 0;
    always @(negedge cs_n or negedge ser_clk) begin
        if (ser_clk) begin
            fcnt = 0;
            ser_in = lead_val;
        end else begin
            fcnt = fcnt + 1;
            if (fcnt <= LEAD)       ser_in = lead_val;
            else if (fcnt <= TOTAL) ser_in = conv_word[TOTAL - fcnt];
            else                    ser_in = 1'b0;
        end
    end

    // port monitor, sampled away from the active edge
    int cyc = 0, n_fall = 0, n_valid = 0, last_fall = 0, interval = 0;
    int hi_run = 0, gap_last = 0, rises = 0, frame_rises = 0, last_sfall = 0;
    bit per_bad = 0, frame_per_bad = 0, v_on_rise = 0, v_double = 0, cs_p = 1, sclk_p = 1, v_p = 0;
    bit idle_low = 0;
    logic [DATA_W-1:0] vdata = '0;
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            cs_p = 1; sclk_p = 1; v_p = 0; rises = 0; hi_run = 0;
        end else begin
            if (cs_p && !cs_n) begin
                n_fall++; interval = cyc - last_fall; last_fall = cyc;
                gap_last = hi_run; rises = 0; last_sfall = 0; per_bad = 0;
            end
            if (cs_n) hi_run++; else hi_run = 0;
            if (cs_n && !ser_clk) idle_low = 1;
            if (!cs_n && ser_clk && !sclk_p) rises++;
            if (!cs_n && !ser_clk && sclk_p) begin
                if (last_sfall != 0 && (cyc - last_sfall) != 2 * HALF) per_bad = 1;
                last_sfall = cyc;
            end
            if (!cs_p && cs_n) begin frame_rises = rises; frame_per_bad = per_bad; end
            if (sample_valid) begin
                n_valid++; vdata = sample_data; v_on_rise = (!cs_p && cs_n);
                if (v_p) v_double = 1;
            end
            v_p = sample_valid; cs_p = cs_n; sclk_p = ser_clk;
        end
    end

    task automatic wait_falls(input int n);
        int target = n_fall + n;
        while (n_fall < target) @(negedge clk);
    endtask

    task automatic wait_valid();
        int target = n_valid + 1;
        while (n_valid < target) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 cs_n in reset", 32'(cs_n), 1);
        chk("R1 ser_clk in reset", 32'(ser_clk), 1);
        chk("R1 valid in reset", 32'(sample_valid), 0);
        chk("R1 data in reset", 32'(sample_data), 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 cs_n after release", 32'(cs_n), 1);
        chk("R1 valid after release", 32'(n_valid), 0);
    endtask

    task automatic t_word(input logic [DATA_W-1:0] w, input logic lv, input string tag);
        wait_valid();
        conv_word = w; lead_val = lv;
        wait_valid();
        chk(tag, 32'(vdata), 32'(w));
        chk("R5 valid with cs_n rise", 32'(v_on_rise), 1);
        chk("R3 22 rising serial edges", 32'(frame_rises), TOTAL);
        chk("R3 serial period", 32'(frame_per_bad), 0);
        repeat (2 * HALF + 3) @(negedge clk);
        chk("R5 data held", 32'(sample_data), 32'(w));
    endtask

    task automatic t_rate();
        rate_sel = 1'b1;
        wait_falls(1);
        wait_falls(1);
        chk("R2 fast interval", 32'(interval), FASTP);
        chk("R6 idle gap", 32'(gap_last >= 2 * HALF), 1);
        repeat (30) @(negedge clk);
        rate_sel = 1'b0;
        wait_falls(1);
        chk("R7 mid-period change ignored", 32'(interval), FASTP);
        wait_falls(1);
        chk("R2 slow interval", 32'(interval), SLOWP);
        chk("R6 idle gap slow", 32'(gap_last >= 2 * HALF), 1);
    endtask

    task automatic t_mid_reset();
        int nv;
        wait_valid();
        conv_word = 16'hC3A5; lead_val = 1'b0;
        wait_falls(1);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nv = n_valid;
        chk("R8 data cleared", 32'(sample_data), 0);
        wait_falls(1);
        chk("R8 no strobe from cut frame", 32'(n_valid), 32'(nv));
        wait_valid();
        chk("R8 full word after reset", 32'(vdata), 32'hC3A5);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_word(16'hA55A, 1'b1, "R4 word A55A, lead ones ignored");
        t_word(16'h0000, 1'b1, "R4 zero word, lead ones ignored");
        t_word(16'hFFFF, 1'b0, "R4 all-ones word");
        t_word(16'h8001, 1'b1, "R4 MSB and LSB positions");
        t_rate();
        t_word(16'h1234, 1'b0, "R4 word 1234 at fast rate");
        t_mid_reset();
        chk("R5 no double strobe", 32'(v_double), 0);
        chk("R3 serial clock idle high", 32'(idle_low), 0);
        summary();
        $finish;
    end
endmodule